// File: doc/BRIEF.md
# Scratchpad Row ReLU Engine

The engine applies an element-wise rectifier to a run of scratchpad rows. A host hands it one command at a time through a valid/ready request port. Each command names a tag, a source bank, a destination bank, a first row and a row count. The engine then streams the rows out of the source bank, one read per cycle. It forces every negative signed lane to zero and writes each transformed row to the same row index in the destination bank. When the last write has been issued, it raises a response that carries the command's tag.

The scratchpad sits outside the block. The engine drives a read port with a one-cycle data latency and a separate write port, so the source and destination banks can be active in the same cycle. A command that names the same bank for both accesses, or that asks for zero rows, is refused. The engine then answers at once with an error flag and touches no memory. Two status outputs show the host when the engine is idle and mark the cycle in which a response is taken.

Top module: `relu_row_engine`

## Requirements
- R1: While reset is active and after it is released, the engine is idle: `req_ready`=1, `stat_idle`=1, and `rsp_valid`, `rd_en` and `wr_en` are all 0.
- R2: `req_ready` is 1 only while the engine is idle. A command is taken only in a cycle where `req_valid` and `req_ready` are both 1. Request activity while the engine is busy has no effect.
- R3: Each lane of a written row is LANE_W bits wide, lane 0 in the least significant bits, read as two's complement. A lane whose top bit is 1 is written as 0, and any other lane is written unchanged.
- R4: A valid command reads rows start, start+1, … (modulo ROWS, which is a power of two) from the source bank. It writes exactly `req_count` rows, each to the same row index in the destination bank, and changes no other location.
- R5: Each row write is issued two cycles after the read of that row: the read data arrives one cycle after the read, and the write follows in the next cycle.
- R6: `rsp_tag` equals the tag captured with the command.
- R7: If the source bank equals the destination bank, or `req_count` is 0, the command is accepted. Its response is valid in the cycle after acceptance, with `rsp_err`=1, and it issues no read and no write. Otherwise `rsp_err`=0.
- R8: Once `rsp_valid` is 1, it stays 1 with `rsp_tag` and `rsp_err` unchanged until a cycle in which `rsp_ready` is 1.
- R9: `stat_complete` is 1 exactly in the cycles where `rsp_valid` and `rsp_ready` are both 1. After that cycle the engine is idle again.
- R10: For a valid command of N rows, accepted at clock edge E0, `rsp_valid` first reads 1 after edge E0+N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Engine can take a command |
| req_tag | input | TAG_W | Reorder tag of the command |
| req_src_bank | input | BANK_W | Bank the rows are read from |
| req_dst_bank | input | BANK_W | Bank the rows are written to |
| req_start_row | input | ROW_W | First row index |
| req_count | input | CNT_W | Number of rows |
| rsp_valid | output | 1 | Completion offered |
| rsp_ready | input | 1 | Host takes the completion |
| rsp_tag | output | TAG_W | Tag echoed from the command |
| rsp_err | output | 1 | Command refused (bank clash or zero rows) |
| rd_en | output | 1 | Scratchpad read strobe |
| rd_bank | output | BANK_W | Read bank |
| rd_row | output | ROW_W | Read row |
| rd_data | input | LANES*LANE_W | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Scratchpad write strobe |
| wr_bank | output | BANK_W | Write bank |
| wr_row | output | ROW_W | Write row |
| wr_data | output | LANES*LANE_W | Rectified row |
| stat_idle | output | 1 | Engine idle |
| stat_complete | output | 1 | Completion taken this cycle |

## Verification
The assertions take for granted that the scratchpad returns read data exactly one cycle after `rd_en` and that nothing else writes the source bank while a command runs. They also assume the host keeps request fields steady only for the handshake cycle and never relies on them afterward. The bench owns the scratchpad model, so it always answers with one-cycle latency and is the only writer. Its stimulus draws banks, rows, counts, tags and response stalls from a seeded generator. While the engine is busy, it sometimes holds `req_valid` high with a conflicting command, which the engine must ignore.

// File: rtl/relu_eng_pkg.sv
package relu_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COMPUTE = 2'd1,
    ST_DONE    = 2'd2
  } eng_state_t;
endpackage

// File: rtl/relu_lanes.sv
module relu_lanes #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] row_in,
  output logic [LANES*LANE_W-1:0] row_out
);
  // A lane is negative when its sign bit is set; such lanes become zero.
  function automatic logic [LANE_W-1:0] clamp_lane(input logic [LANE_W-1:0] v);
    return v[LANE_W-1] ? '0 : v;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign row_out[g*LANE_W +: LANE_W] = clamp_lane(row_in[g*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/relu_ctrl.sv
module relu_ctrl
  import relu_eng_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [BANK_W-1:0] req_src_bank,
  input  logic [BANK_W-1:0] req_dst_bank,
  input  logic [ROW_W-1:0]  req_start_row,
  input  logic [CNT_W-1:0]  req_count,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_err,
  output logic              rd_en,
  output logic [BANK_W-1:0] rd_bank,
  output logic [ROW_W-1:0]  rd_row,
  output logic [BANK_W-1:0] dst_bank,
  input  logic              wr_fire,
  output logic              cmd_accept,
  output logic              rsp_fire,
  output eng_state_t        state_o
);
  eng_state_t        state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [BANK_W-1:0] src_q, dst_q;
  logic [ROW_W-1:0]  start_q;
  logic [CNT_W-1:0]  cnt_q, rd_cnt_q, wr_cnt_q;
  logic              err_q;
  logic              cmd_bad;
  logic              last_write;

  assign req_ready  = (state_q == ST_IDLE);
  assign cmd_accept = req_valid && req_ready;
  assign cmd_bad    = (req_src_bank == req_dst_bank) || (req_count == '0);
  assign rsp_valid  = (state_q == ST_DONE);
  assign rsp_fire   = rsp_valid && rsp_ready;
  assign last_write = wr_fire && (wr_cnt_q == CNT_W'(cnt_q - 1'b1));

  assign rd_en    = (state_q == ST_COMPUTE) && (rd_cnt_q < cnt_q);
  assign rd_bank  = src_q;
  assign rd_row   = start_q + rd_cnt_q[ROW_W-1:0];
  assign dst_bank = dst_q;
  assign rsp_tag  = tag_q;
  assign rsp_err  = err_q;
  assign state_o  = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tag_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      start_q  <= '0;
      cnt_q    <= '0;
      rd_cnt_q <= '0;
      wr_cnt_q <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_accept) begin
            tag_q    <= req_tag;
            src_q    <= req_src_bank;
            dst_q    <= req_dst_bank;
            start_q  <= req_start_row;
            cnt_q    <= req_count;
            rd_cnt_q <= '0;
            wr_cnt_q <= '0;
            err_q    <= cmd_bad;
            state_q  <= cmd_bad ? ST_DONE : ST_COMPUTE;
          end
        end
        ST_COMPUTE: begin
          if (rd_en)   rd_cnt_q <= rd_cnt_q + 1'b1;
          if (wr_fire) wr_cnt_q <= wr_cnt_q + 1'b1;
          if (last_write) state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/relu_wr_stage.sv
module relu_wr_stage #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [DATA_W-1:0] clamped,
  output logic              data_here,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [DATA_W-1:0] wr_data
);
  logic [ROW_W-1:0] pend_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_here  <= 1'b0;
      pend_row_q <= '0;
      wr_en      <= 1'b0;
      wr_row     <= '0;
      wr_data    <= '0;
    end else begin
      data_here  <= rd_en;
      pend_row_q <= rd_row;
      wr_en      <= data_here;
      if (data_here) begin
        wr_row  <= pend_row_q;
        wr_data <= clamped;
      end
    end
  end
endmodule

// File: rtl/relu_row_engine.sv
module relu_row_engine
  import relu_eng_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int NBANKS = 4,
  parameter int ROWS   = 16,
  parameter int TAG_W  = 4,
  localparam int BANK_W = $clog2(NBANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int CNT_W  = $clog2(ROWS + 1),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [BANK_W-1:0] req_src_bank,
  input  logic [BANK_W-1:0] req_dst_bank,
  input  logic [ROW_W-1:0]  req_start_row,
  input  logic [CNT_W-1:0]  req_count,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_err,
  output logic              rd_en,
  output logic [BANK_W-1:0] rd_bank,
  output logic [ROW_W-1:0]  rd_row,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [BANK_W-1:0] wr_bank,
  output logic [ROW_W-1:0]  wr_row,
  output logic [DATA_W-1:0] wr_data,
  output logic              stat_idle,
  output logic              stat_complete
);
  // Named internal events, visible to the bound checker.
  logic              cmd_accept;
  logic              rsp_fire;
  logic              data_here;
  logic [DATA_W-1:0] clamped_row;
  eng_state_t        eng_state;

  relu_ctrl #(
    .TAG_W (TAG_W),
    .BANK_W(BANK_W),
    .ROW_W (ROW_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_tag      (req_tag),
    .req_src_bank (req_src_bank),
    .req_dst_bank (req_dst_bank),
    .req_start_row(req_start_row),
    .req_count    (req_count),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_tag      (rsp_tag),
    .rsp_err      (rsp_err),
    .rd_en        (rd_en),
    .rd_bank      (rd_bank),
    .rd_row       (rd_row),
    .dst_bank     (wr_bank),
    .wr_fire      (wr_en),
    .cmd_accept   (cmd_accept),
    .rsp_fire     (rsp_fire),
    .state_o      (eng_state)
  );

  relu_lanes #(
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_lanes (
    .row_in (rd_data),
    .row_out(clamped_row)
  );

  relu_wr_stage #(
    .DATA_W(DATA_W),
    .ROW_W (ROW_W)
  ) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_row   (rd_row),
    .clamped  (clamped_row),
    .data_here(data_here),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .wr_data  (wr_data)
  );

  assign stat_idle     = (eng_state == ST_IDLE);
  assign stat_complete = rsp_fire;
endmodule

// File: rtl/relu_row_engine_chk.sv
module relu_row_engine_chk #(
  parameter int TAG_W  = 4,
  parameter int BANK_W = 2,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [TAG_W-1:0]        rsp_tag,
  input logic                    rsp_err,
  input logic                    rd_en,
  input logic [BANK_W-1:0]       rd_bank,
  input logic                    wr_en,
  input logic [BANK_W-1:0]       wr_bank,
  input logic [LANES*LANE_W-1:0] wr_data,
  input logic                    data_here,
  input logic                    stat_idle,
  input logic                    stat_complete
);
  function automatic logic any_sign(input logic [LANES*LANE_W-1:0] v);
    logic s;
    s = 1'b0;
    for (int i = 0; i < LANES; i++) s = s | v[i*LANE_W + LANE_W - 1];
    return s;
  endfunction

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_idle |-> (!rd_en && !wr_en && !rsp_valid));

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_neg_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !any_sign(wr_data));

  assert_wr_two_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> data_here ##1 wr_en);

  assert_banks_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_bank != rd_bank));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) && $stable(rsp_err)));

  assert_complete_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_complete == (rsp_valid && rsp_ready));

  assert_idle_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_complete |=> stat_idle);
endmodule

bind relu_row_engine relu_row_engine_chk #(
  .TAG_W (TAG_W),
  .BANK_W(BANK_W),
  .LANES (LANES),
  .LANE_W(LANE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_tag      (rsp_tag),
  .rsp_err      (rsp_err),
  .rd_en        (rd_en),
  .rd_bank      (rd_bank),
  .wr_en        (wr_en),
  .wr_bank      (wr_bank),
  .wr_data      (wr_data),
  .data_here    (data_here),
  .stat_idle    (stat_idle),
  .stat_complete(stat_complete)
);

// File: tb/relu_row_engine_bench.sv
`timescale 1ns/1ps
module relu_row_engine_bench;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int NBANKS = 4;
  localparam int ROWS   = 16;
  localparam int TAG_W  = 4;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 4;
  localparam int CNT_W  = 5;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [TAG_W-1:0]  req_tag = '0;
  logic [BANK_W-1:0] req_src_bank = '0;
  logic [BANK_W-1:0] req_dst_bank = '0;
  logic [ROW_W-1:0]  req_start_row = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [TAG_W-1:0]  rsp_tag;
  logic              rsp_err;
  logic              rd_en;
  logic [BANK_W-1:0] rd_bank;
  logic [ROW_W-1:0]  rd_row;
  logic [DATA_W-1:0] rd_data = '0;
  logic              wr_en;
  logic [BANK_W-1:0] wr_bank;
  logic [ROW_W-1:0]  wr_row;
  logic [DATA_W-1:0] wr_data;
  logic              stat_idle;
  logic              stat_complete;

  int checks = 0;
  int failures = 0;
  int wr_seen = 0;
  int rd_seen = 0;
  logic [DATA_W-1:0] mem [NBANKS*ROWS];
  logic [DATA_W-1:0] expm[NBANKS*ROWS];

  always #2.5 clk = ~clk;

  relu_row_engine #(
    .LANES(LANES), .LANE_W(LANE_W), .NBANKS(NBANKS), .ROWS(ROWS), .TAG_W(TAG_W)
  ) u_relu_row_engine (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .req_src_bank(req_src_bank), .req_dst_bank(req_dst_bank),
    .req_start_row(req_start_row), .req_count(req_count),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_err(rsp_err),
    .rd_en(rd_en), .rd_bank(rd_bank), .rd_row(rd_row), .rd_data(rd_data),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row), .wr_data(wr_data),
    .stat_idle(stat_idle), .stat_complete(stat_complete)
  );

  // Scratchpad model: one-cycle read latency, single writer.
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[int'(rd_bank)*ROWS + int'(rd_row)];
      rd_seen <= rd_seen + 1;
    end
    if (wr_en) begin
      mem[int'(wr_bank)*ROWS + int'(wr_row)] <= wr_data;
      wr_seen <= wr_seen + 1;
    end
  end

  // Rectifier restated: signed compare per lane.
  function automatic logic [DATA_W-1:0] ref_rect(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      if ($signed(v[i*LANE_W +: LANE_W]) < 0) r[i*LANE_W +: LANE_W] = '0;
      else r[i*LANE_W +: LANE_W] = v[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_cmd(input logic [TAG_W-1:0] tag, input logic [BANK_W-1:0] src,
                         input logic [BANK_W-1:0] dst, input logic [ROW_W-1:0] start,
                         input logic [CNT_W-1:0] cnt, input int hold, input bit junk);
    bit bad;
    int w0, r0, lat, exp_lat, miss;
    bad = (src == dst) || (cnt == 0);
    if (!bad)
      for (int k = 0; k < int'(cnt); k++) begin
        int r;
        r = (int'(start) + k) % ROWS;
        expm[int'(dst)*ROWS + r] = ref_rect(expm[int'(src)*ROWS + r]);
      end
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_tag = tag; req_src_bank = src; req_dst_bank = dst;
    req_start_row = start; req_count = cnt;
    w0 = wr_seen; r0 = rd_seen;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      req_tag = ~tag; req_src_bank = dst; req_dst_bank = src; req_count = 5'd5;
    end else req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 not ready when busy", req_ready, 0);
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    exp_lat = bad ? 0 : int'(cnt) + 2;
    chk(lat == exp_lat, bad ? "R7 immediate response" : "R10 R5 response latency", lat, exp_lat);
    chk(rsp_tag == tag, "R6 tag echoed", rsp_tag, tag);
    chk(rsp_err == bad, "R7 error flag", rsp_err, bad);
    for (int i = 0; i < hold; i++) begin
      chk(stat_complete == 1'b0, "R9 no pulse while stalled", stat_complete, 0);
      @(negedge clk);
      chk(rsp_valid && rsp_tag == tag && rsp_err == bad, "R8 response held", rsp_tag, tag);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    #1;
    chk(stat_complete == 1'b1, "R9 pulse on handshake", stat_complete, 1);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && stat_idle, "R9 idle after handshake", {rsp_valid, stat_idle}, 2'b01);
    chk(wr_seen - w0 == (bad ? 0 : int'(cnt)), "R4 write count", wr_seen - w0, bad ? 0 : cnt);
    if (bad) chk(rd_seen == r0, "R7 no reads", rd_seen - r0, 0);
    miss = 0;
    for (int a = 0; a < NBANKS*ROWS; a++) if (mem[a] !== expm[a]) miss++;
    chk(miss == 0, "R4 R3 memory contents", miss, 0);
  endtask

  initial begin
    int n;
    n = 0;
    while (n < 200000) begin
      @(posedge clk);
      n++;
    end
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", n);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    for (int a = 0; a < NBANKS*ROWS; a++) begin
      mem[a] = $urandom;
      expm[a] = mem[a];
    end
    #1;
    chk(req_ready && stat_idle && !rsp_valid && !rd_en && !wr_en, "R1 in reset",
        {req_ready, stat_idle, rsp_valid, rd_en, wr_en}, 5'b11000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && stat_idle && !rsp_valid && !rd_en && !wr_en, "R1 after reset",
        {req_ready, stat_idle, rsp_valid, rd_en, wr_en}, 5'b11000);

    // Lane boundary values (R3): lane3..0 = 80,7F,00,FF -> 00,7F,00,00
    mem[0*ROWS + 3] = 32'h807F_00FF;
    expm[0*ROWS + 3] = 32'h807F_00FF;
    run_cmd(4'h3, 2'd0, 2'd1, 4'd3, 5'd1, 0, 1'b0);
    chk(mem[1*ROWS + 3] == 32'h007F_0000, "R3 boundary lanes", mem[1*ROWS + 3], 32'h007F_0000);

    run_cmd(4'h9, 2'd2, 2'd3, 4'd9, 5'd16, 2, 1'b1);   // full wrap, junk request while busy
    run_cmd(4'h5, 2'd1, 2'd1, 4'd0, 5'd4, 1, 1'b0);    // same bank: refused
    run_cmd(4'hA, 2'd0, 2'd2, 4'd7, 5'd0, 0, 1'b0);    // zero rows: refused
    run_cmd(4'hF, 2'd3, 2'd0, 4'd15, 5'd2, 0, 1'b1);   // wrap across last row

    for (int t = 0; t < 24; t++) begin
      logic [BANK_W-1:0] s, d;
      s = BANK_W'($urandom_range(0, NBANKS-1));
      d = BANK_W'($urandom_range(0, NBANKS-1));
      if ($urandom_range(0, 7) != 0 && d == s) d = s + 1'b1;
      run_cmd(TAG_W'($urandom), s, d, ROW_W'($urandom), CNT_W'($urandom_range(0, ROWS)),
              $urandom_range(0, 3), bit'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule